// File: doc/BRIEF.md
# Timed RAM Waveform Playback Controller

This block stores waveform samples in an on-chip word memory and plays them out, one word per programmable interval, onto the parameter inputs of a digital synthesizer. Eight playback profiles are held in a small register bank. Each profile records a first address, a last address, an interval count and a target parameter. The target is the frequency tuning word, the phase offset, the amplitude scale, or a polar pair that takes phase and magnitude from the same word.

A three-bit selector picks the profile. A change on the selector is taken only on a cycle flagged by `sync_tick`, which marks the rising edge of the slower synchronisation clock. Playback starts when `play_en` is high and either `upd_strobe` is pulsed or an accepted selector change occurs. The player then walks upward from the first address and holds the final word once the last address has been presented. After the last word has been shown for one full interval, it raises `sweep_done`. A separate write port loads words into the memory at any time.

Top module: `wavemem_player`

## Requirements
- R1: A word written through the memory load port (`mem_we`, `mem_addr`, `mem_wdata`) is the word presented when playback later reaches that address.
- R2: A start happens on a clock edge where `play_en`=1 and either `upd_strobe`=1 or an accepted profile change occurs. With `play_en`=0, a strobe neither starts playback nor clears `sweep_done`.
- R3: A selector value that differs from the active profile is accepted only on an edge where `sync_tick`=1. Before that edge, nothing starts.
- R4: With an effective interval R, the address equals first+k from start edge + k·R. The word at that address appears on the outputs one edge later.
- R5: An interval value of 0 behaves as an interval of 1, so a new word is read every clock.
- R6: If the last address is not above the first address, only the word at the first address is played.
- R7: After the last address, the last word stays on the outputs and `sweep_done` stays 1 until the next start.
- R8: `sweep_done` rises n·R edges after the start edge, where n is the number of words played. It reads 0 after every start edge.
- R9: Target code 0 (frequency) drives all 32 bits of the word on `freq_word` with `freq_vld`=1. The other valid flags are then 0.
- R10: Target code 1 (phase) drives word bits [31:16] on `phase_word`. Target code 2 (amplitude) drives word bits [31:18] on `ampl_word`.
- R11: Target code 3 (polar) drives word bits [31:16] on `phase_word` and word bits [15:2] on `ampl_word`, with both valid flags set.
- R12: After reset, every output is 0.
- R13: While `play_en`=0, all valid flags are 0 and all parameter words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sync_tick | input | 1 | Marks the synchronisation-clock rising edge |
| prof_sel | input | PSEL_W | Profile selector |
| play_en | input | 1 | Playback enable |
| upd_strobe | input | 1 | Start request |
| cfg_we | input | 1 | Profile bank write enable |
| cfg_idx | input | PSEL_W | Profile entry to write |
| cfg_start | input | ADDR_W | First address |
| cfg_end | input | ADDR_W | Last address |
| cfg_rate | input | TIMER_W | Clocks per word (0 means 1) |
| cfg_dest | input | 2 | Target code: 0 frequency, 1 phase, 2 amplitude, 3 polar |
| mem_we | input | 1 | Memory write enable |
| mem_addr | input | ADDR_W | Memory write address |
| mem_wdata | input | DATA_W | Memory write data |
| freq_word | output | DATA_W | Frequency tuning word |
| freq_vld | output | 1 | Frequency word driven by playback |
| phase_word | output | PH_W | Phase offset |
| phase_vld | output | 1 | Phase driven by playback |
| ampl_word | output | AMP_W | Amplitude scale |
| ampl_vld | output | 1 | Amplitude driven by playback |
| sweep_done | output | 1 | Sweep of the active profile finished |

## Verification
The bench builds the block with a 6-bit address (64 words) and an 8-bit interval counter, keeping the other parameters at their defaults. The small memory puts the top address within reach, so a sweep that ends at word 63 tests that the walk stops there without wrapping. The narrow counter keeps every interval short enough to follow each word cycle by cycle. Profiles of different lengths and intervals, including a zero interval and an inverted address range, are started through both the strobe path and the profile-change path.

// File: rtl/wp_pkg.sv
package wp_pkg;
   typedef enum logic [1:0] {
      DST_FREQ  = 2'd0,
      DST_PHASE = 2'd1,
      DST_AMPL  = 2'd2,
      DST_POLAR = 2'd3
   } dest_e;
endpackage

// File: rtl/wp_prof_bank.sv
module wp_prof_bank
   import wp_pkg::*;
#(
   parameter int NUM_PROF = 8,
   parameter int ADDR_W   = 10,
   parameter int TIMER_W  = 16,
   localparam int IDX_W   = $clog2(NUM_PROF)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [ADDR_W-1:0]  wr_first,
   input  logic [ADDR_W-1:0]  wr_last,
   input  logic [TIMER_W-1:0] wr_rate,
   input  dest_e              wr_dest,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [ADDR_W-1:0]  rd_first,
   output logic [ADDR_W-1:0]  rd_last,
   output logic [TIMER_W-1:0] rd_rate,
   output dest_e              rd_dest
);
   logic [ADDR_W-1:0]  first_a [NUM_PROF];
   logic [ADDR_W-1:0]  last_a  [NUM_PROF];
   logic [TIMER_W-1:0] rate_a  [NUM_PROF];
   dest_e              dest_a  [NUM_PROF];

   for (genvar i = 0; i < NUM_PROF; i++) begin : g_entry
      logic [ADDR_W-1:0]  first_q;
      logic [ADDR_W-1:0]  last_q;
      logic [TIMER_W-1:0] rate_q;
      dest_e              dest_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            first_q <= '0;
            last_q  <= '0;
            rate_q  <= '0;
            dest_q  <= DST_FREQ;
         end else if (wr_en && (wr_idx == IDX_W'(i))) begin
            first_q <= wr_first;
            last_q  <= wr_last;
            rate_q  <= wr_rate;
            dest_q  <= wr_dest;
         end
      end
      assign first_a[i] = first_q;
      assign last_a[i]  = last_q;
      assign rate_a[i]  = rate_q;
      assign dest_a[i]  = dest_q;
   end

   assign rd_first = first_a[rd_idx];
   assign rd_last  = last_a[rd_idx];
   assign rd_rate  = rate_a[rd_idx];
   assign rd_dest  = dest_a[rd_idx];
endmodule

// File: rtl/wp_sample_ram.sv
module wp_sample_ram #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) store[wr_addr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_data <= '0;
      else        rd_data <= store[rd_addr];
   end
endmodule

// File: rtl/wp_sequencer.sv
module wp_sequencer
   import wp_pkg::*;
#(
   parameter int ADDR_W  = 10,
   parameter int TIMER_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [ADDR_W-1:0]  first_i,
   input  logic [ADDR_W-1:0]  last_i,
   input  logic [TIMER_W-1:0] rate_i,
   input  dest_e              dest_i,
   output logic [ADDR_W-1:0]  addr_o,
   output logic               busy_o,
   output logic               done_o,
   output dest_e              dest_o,
   output logic [TIMER_W-1:0] cnt_o,
   output logic [ADDR_W-1:0]  first_o,
   output logic [ADDR_W-1:0]  last_o
);
   logic [TIMER_W-1:0] eff_rate;
   logic [TIMER_W-1:0] reload_q;
   logic               at_last;

   assign eff_rate = (rate_i == '0) ? TIMER_W'(1) : rate_i;
   assign at_last  = (addr_o >= last_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_o   <= '0;
         first_o  <= '0;
         last_o   <= '0;
         cnt_o    <= '0;
         reload_q <= '0;
         busy_o   <= 1'b0;
         done_o   <= 1'b0;
         dest_o   <= DST_FREQ;
      end else if (start_i) begin
         addr_o   <= first_i;
         first_o  <= first_i;
         last_o   <= last_i;
         cnt_o    <= eff_rate;
         reload_q <= eff_rate;
         busy_o   <= 1'b1;
         done_o   <= 1'b0;
         dest_o   <= dest_i;
      end else if (busy_o) begin
         if (cnt_o == TIMER_W'(1)) begin
            if (at_last) begin
               busy_o <= 1'b0;
               done_o <= 1'b1;
            end else begin
               addr_o <= addr_o + ADDR_W'(1);
               cnt_o  <= reload_q;
            end
         end else begin
            cnt_o <= cnt_o - TIMER_W'(1);
         end
      end
   end
endmodule

// File: rtl/wp_router.sv
module wp_router
   import wp_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int PH_W    = 16,
   parameter int AMP_W   = 14,
   parameter int OUT_REG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  dest_e             dest_i,
   input  logic [DATA_W-1:0] word_i,
   output logic [DATA_W-1:0] freq_o,
   output logic              freq_v,
   output logic [PH_W-1:0]   ph_o,
   output logic              ph_v,
   output logic [AMP_W-1:0]  amp_o,
   output logic              amp_v
);
   localparam int MAG_LSB = DATA_W - PH_W - AMP_W;

   logic [DATA_W-1:0] w;
   dest_e             d;

   if (OUT_REG != 0) begin : g_staged
      logic [DATA_W-1:0] w_q;
      dest_e             d_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            w_q <= '0;
            d_q <= DST_FREQ;
         end else begin
            w_q <= word_i;
            d_q <= dest_i;
         end
      end
      assign w = w_q;
      assign d = d_q;
   end else begin : g_direct
      assign w = word_i;
      assign d = dest_i;
   end

   always_comb begin
      freq_o = '0;
      freq_v = 1'b0;
      ph_o   = '0;
      ph_v   = 1'b0;
      amp_o  = '0;
      amp_v  = 1'b0;
      if (en) begin
         unique case (d)
            DST_FREQ: begin
               freq_o = w;
               freq_v = 1'b1;
            end
            DST_PHASE: begin
               ph_o = w[DATA_W-1 -: PH_W];
               ph_v = 1'b1;
            end
            DST_AMPL: begin
               amp_o = w[DATA_W-1 -: AMP_W];
               amp_v = 1'b1;
            end
            DST_POLAR: begin
               ph_o  = w[DATA_W-1 -: PH_W];
               ph_v  = 1'b1;
               amp_o = w[MAG_LSB +: AMP_W];
               amp_v = 1'b1;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/wavemem_player.sv
module wavemem_player
   import wp_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 10,
   parameter int TIMER_W  = 16,
   parameter int NUM_PROF = 8,
   parameter int PH_W     = 16,
   parameter int AMP_W    = 14,
   parameter int OUT_REG  = 0,
   localparam int PSEL_W  = $clog2(NUM_PROF)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sync_tick,
   input  logic [PSEL_W-1:0]  prof_sel,
   input  logic               play_en,
   input  logic               upd_strobe,
   input  logic               cfg_we,
   input  logic [PSEL_W-1:0]  cfg_idx,
   input  logic [ADDR_W-1:0]  cfg_start,
   input  logic [ADDR_W-1:0]  cfg_end,
   input  logic [TIMER_W-1:0] cfg_rate,
   input  logic [1:0]         cfg_dest,
   input  logic               mem_we,
   input  logic [ADDR_W-1:0]  mem_addr,
   input  logic [DATA_W-1:0]  mem_wdata,
   output logic [DATA_W-1:0]  freq_word,
   output logic               freq_vld,
   output logic [PH_W-1:0]    phase_word,
   output logic               phase_vld,
   output logic [AMP_W-1:0]   ampl_word,
   output logic               ampl_vld,
   output logic               sweep_done
);
   if (DATA_W < PH_W + AMP_W) begin : g_bad_split
      initial $fatal(1, "word too narrow for the polar split");
   end
   if ((1 << PSEL_W) != NUM_PROF || NUM_PROF < 2) begin : g_bad_prof
      initial $fatal(1, "profile count must be a power of two of at least 2");
   end
   if (ADDR_W < 1 || TIMER_W < 1) begin : g_bad_width
      initial $fatal(1, "address and timer widths must be positive");
   end

   logic [PSEL_W-1:0]  act_q;
   logic               live_q;
   logic               prof_chg;
   logic               start;
   logic [PSEL_W-1:0]  sel_idx;

   logic [ADDR_W-1:0]  bk_first;
   logic [ADDR_W-1:0]  bk_last;
   logic [TIMER_W-1:0] bk_rate;
   dest_e              bk_dest;

   logic [ADDR_W-1:0]  seq_addr;
   logic               seq_busy;
   dest_e              seq_dest;
   logic [TIMER_W-1:0] seq_cnt;
   logic [ADDR_W-1:0]  seq_first;
   logic [ADDR_W-1:0]  seq_last;
   logic [DATA_W-1:0]  ram_q;

   assign prof_chg = sync_tick && (prof_sel != act_q);
   assign sel_idx  = prof_chg ? prof_sel : act_q;
   assign start    = play_en && (upd_strobe || prof_chg);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= '0;
         live_q <= 1'b0;
      end else begin
         if (prof_chg) act_q  <= prof_sel;
         if (start)    live_q <= 1'b1;
      end
   end

   wp_prof_bank #(
      .NUM_PROF (NUM_PROF),
      .ADDR_W   (ADDR_W),
      .TIMER_W  (TIMER_W)
   ) bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_idx   (cfg_idx),
      .wr_first (cfg_start),
      .wr_last  (cfg_end),
      .wr_rate  (cfg_rate),
      .wr_dest  (dest_e'(cfg_dest)),
      .rd_idx   (sel_idx),
      .rd_first (bk_first),
      .rd_last  (bk_last),
      .rd_rate  (bk_rate),
      .rd_dest  (bk_dest)
   );

   wp_sequencer #(
      .ADDR_W  (ADDR_W),
      .TIMER_W (TIMER_W)
   ) seq_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .first_i (bk_first),
      .last_i  (bk_last),
      .rate_i  (bk_rate),
      .dest_i  (bk_dest),
      .addr_o  (seq_addr),
      .busy_o  (seq_busy),
      .done_o  (sweep_done),
      .dest_o  (seq_dest),
      .cnt_o   (seq_cnt),
      .first_o (seq_first),
      .last_o  (seq_last)
   );

   wp_sample_ram #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) ram_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (mem_we),
      .wr_addr (mem_addr),
      .wr_data (mem_wdata),
      .rd_addr (seq_addr),
      .rd_data (ram_q)
   );

   wp_router #(
      .DATA_W  (DATA_W),
      .PH_W    (PH_W),
      .AMP_W   (AMP_W),
      .OUT_REG (OUT_REG)
   ) route_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (play_en && live_q),
      .dest_i (seq_dest),
      .word_i (ram_q),
      .freq_o (freq_word),
      .freq_v (freq_vld),
      .ph_o   (phase_word),
      .ph_v   (phase_vld),
      .amp_o  (ampl_word),
      .amp_v  (ampl_vld)
   );
endmodule

// File: rtl/wavemem_player_chk.sv
module wavemem_player_chk #(
   parameter int ADDR_W  = 10,
   parameter int TIMER_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               play_en,
   input logic               upd_strobe,
   input logic               sync_tick,
   input logic               freq_vld,
   input logic               phase_vld,
   input logic               ampl_vld,
   input logic               sweep_done,
   input logic               seq_busy,
   input logic [TIMER_W-1:0] seq_cnt,
   input logic [ADDR_W-1:0]  seq_addr,
   input logic [ADDR_W-1:0]  seq_first,
   input logic [ADDR_W-1:0]  seq_last
);
   assert_cnt_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      seq_busy |-> (seq_cnt != '0));

   assert_addr_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      seq_busy |-> ((seq_addr >= seq_first) && ((seq_addr <= seq_last) || (seq_addr == seq_first))));

   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sweep_done |-> !seq_busy);

   assert_done_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (play_en && upd_strobe) |=> !sweep_done);

   assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sweep_done && !(play_en && (upd_strobe || sync_tick))) |=> sweep_done);

   assert_freq_alone_R9: assert property (@(posedge clk) disable iff (!rst_n)
      freq_vld |-> (!phase_vld && !ampl_vld));

   assert_off_silent_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !play_en |-> !(freq_vld || phase_vld || ampl_vld));
endmodule

bind wavemem_player wavemem_player_chk #(
   .ADDR_W  (ADDR_W),
   .TIMER_W (TIMER_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .play_en    (play_en),
   .upd_strobe (upd_strobe),
   .sync_tick  (sync_tick),
   .freq_vld   (freq_vld),
   .phase_vld  (phase_vld),
   .ampl_vld   (ampl_vld),
   .sweep_done (sweep_done),
   .seq_busy   (seq_busy),
   .seq_cnt    (seq_cnt),
   .seq_addr   (seq_addr),
   .seq_first  (seq_first),
   .seq_last   (seq_last)
);

// File: tb/wavemem_player_tb.sv
`timescale 1ns/1ps
module wavemem_player_tb_top;
   localparam int AW = 6;
   localparam int TW = 8;
   localparam int NV = 6;

   // vector: [24:22] profile, [21:16] first, [15:10] last, [9:2] interval, [1:0] target
   localparam logic [24:0] VEC [NV] = '{
      {3'd0, 6'd3,  6'd6,  8'd2, 2'd0},
      {3'd5, 6'd10, 6'd12, 8'd0, 2'd1},
      {3'd2, 6'd60, 6'd63, 8'd3, 2'd2},
      {3'd7, 6'd20, 6'd22, 8'd1, 2'd3},
      {3'd3, 6'd40, 6'd40, 8'd4, 2'd0},
      {3'd1, 6'd30, 6'd25, 8'd1, 2'd1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sync_tick = 1'b1;
   logic [2:0] prof_sel = '0;
   logic play_en = 1'b0;
   logic upd_strobe = 1'b0;
   logic cfg_we = 1'b0;
   logic [2:0] cfg_idx = '0;
   logic [AW-1:0] cfg_start = '0;
   logic [AW-1:0] cfg_end = '0;
   logic [TW-1:0] cfg_rate = '0;
   logic [1:0] cfg_dest = '0;
   logic mem_we = 1'b0;
   logic [AW-1:0] mem_addr = '0;
   logic [31:0] mem_wdata = '0;
   logic [31:0] freq_word;
   logic freq_vld;
   logic [15:0] phase_word;
   logic phase_vld;
   logic [13:0] ampl_word;
   logic ampl_vld;
   logic sweep_done;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] shadow [1 << AW];

   always #4 clk = ~clk;

   wavemem_player #(.ADDR_W(AW), .TIMER_W(TW)) dut_i (
      .clk(clk), .rst_n(rst_n), .sync_tick(sync_tick), .prof_sel(prof_sel),
      .play_en(play_en), .upd_strobe(upd_strobe), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_start(cfg_start), .cfg_end(cfg_end), .cfg_rate(cfg_rate), .cfg_dest(cfg_dest),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .freq_word(freq_word), .freq_vld(freq_vld), .phase_word(phase_word),
      .phase_vld(phase_vld), .ampl_word(ampl_word), .ampl_vld(ampl_vld),
      .sweep_done(sweep_done)
   );

   function automatic logic [31:0] data_of(input int a);
      logic [31:0] x;
      x = 32'(a + 1);
      return x * 32'h9E37_79B9;
   endfunction

   function automatic logic [64:0] expect_out(input logic [1:0] d, input logic [31:0] w);
      case (d)
         2'd0:    return {3'b100, w, 16'h0, 14'h0};
         2'd1:    return {3'b010, 32'h0, w[31:16], 14'h0};
         2'd2:    return {3'b001, 32'h0, 16'h0, w[31:18]};
         default: return {3'b011, 32'h0, w[31:16], w[15:2]};
      endcase
   endfunction

   function automatic logic [64:0] dut_out();
      return {freq_vld, phase_vld, ampl_vld, freq_word, phase_word, ampl_word};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [64:0] act, input logic [64:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   // follow one playback cycle by cycle; called half a cycle after the start edge
   task automatic follow(input logic [24:0] v, input string extra);
      int first = int'(v[21:16]);
      int last  = int'(v[15:10]);
      int r     = (v[9:2] == 0) ? 1 : int'(v[9:2]);
      int n     = (last > first) ? (last - first + 1) : 1;
      string tg = (v[1:0] == 2'd0) ? "R9" : (v[1:0] == 2'd3) ? "R11" : "R10";
      for (int m = 0; m <= n * r + 2; m++) begin
         if (m >= 1) begin
            int k = (m - 1) / r;
            logic [64:0] e;
            if (k > n - 1) k = n - 1;
            e = expect_out(v[1:0], shadow[first + k]);
            check(dut_out() === e, $sformatf("R4/%s/%s%s word m=%0d", tg, extra,
                  (m > n * r) ? "/R7" : "", m), dut_out(), e);
         end
         check(sweep_done === (m >= n * r), $sformatf("R8/%s done m=%0d", extra, m),
               65'(sweep_done), 65'(m >= n * r));
         cyc();
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog (all requirements): actual hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) cyc();
      // R12: reset state
      check(dut_out() === 65'h0, "R12 outputs after reset", dut_out(), 65'h0);
      check(sweep_done === 1'b0, "R12 done after reset", 65'(sweep_done), 65'h0);
      rst_n = 1'b1;
      cyc();
      // R1: load memory
      for (int a = 0; a < (1 << AW); a++) begin
         mem_we = 1'b1; mem_addr = AW'(a); mem_wdata = data_of(a);
         shadow[a] = data_of(a);
         cyc();
      end
      mem_we = 1'b0;
      for (int i = 0; i < NV; i++) begin
         cfg_we = 1'b1; cfg_idx = VEC[i][24:22]; cfg_start = VEC[i][21:16];
         cfg_end = VEC[i][15:10]; cfg_rate = VEC[i][9:2]; cfg_dest = VEC[i][1:0];
         cyc();
      end
      cfg_we = 1'b0;
      cyc();

      // table walk: even entries by strobe, odd entries by profile change
      for (int i = 0; i < NV; i++) begin
         string ex = (VEC[i][9:2] == 0) ? "R5" : (VEC[i][15:10] <= VEC[i][21:16]) ? "R6" : "R2";
         if (i % 2 == 0) begin
            play_en = 1'b0;
            prof_sel = VEC[i][24:22];
            cyc(); cyc();
            play_en = 1'b1; upd_strobe = 1'b1;
            cyc();
            upd_strobe = 1'b0;
         end else begin
            play_en = 1'b1;
            prof_sel = VEC[i][24:22];
            cyc();
         end
         follow(VEC[i], ex);
      end

      // R13 and R2: disabled player ignores a strobe
      play_en = 1'b0; upd_strobe = 1'b1;
      cyc();
      upd_strobe = 1'b0;
      cyc();
      check(dut_out() === 65'h0, "R13 outputs while disabled", dut_out(), 65'h0);
      check(sweep_done === 1'b1, "R2 strobe ignored while disabled", 65'(sweep_done), 65'h1);

      // R3: profile change waits for the sync tick
      sync_tick = 1'b0; play_en = 1'b1; prof_sel = 3'd2;
      cyc(); cyc(); cyc();
      check(sweep_done === 1'b1, "R3 no start before sync tick", 65'(sweep_done), 65'h1);
      check(dut_out() === expect_out(2'd1, shadow[30]), "R3 old sample held",
            dut_out(), expect_out(2'd1, shadow[30]));
      sync_tick = 1'b1;
      cyc();
      check(sweep_done === 1'b0, "R3 start on sync tick", 65'(sweep_done), 65'h0);
      cyc();
      check(dut_out() === expect_out(2'd2, shadow[60]), "R3 new profile first word",
            dut_out(), expect_out(2'd2, shadow[60]));
      repeat (14) cyc();

      // R1: rewritten word is played back
      mem_we = 1'b1; mem_addr = 6'd40; mem_wdata = 32'h1234_5678;
      shadow[40] = 32'h1234_5678;
      cyc();
      mem_we = 1'b0;
      prof_sel = 3'd3;
      cyc();
      follow(VEC[4], "R1");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule